// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers up to sixteen level-sensitive interrupt lines from devices on a local peripheral bus. Each line is sampled into a source register whose bits simply track the line levels. A 16-bit enable mask selects which sources may interrupt. The block raises a single combined interrupt request whenever an enabled source is active. A device clears its request by lowering its line, so the controller has no acknowledge, edge capture or nesting.

Software sees two 16-bit registers. The vector register at offset 0 is read-only. It returns a code for the pending source with the lowest index, which lets a handler jump straight to the right service routine without scanning a bitmap. The mask register at offset 2 can be read and written. Byte writes change only the selected half of the mask. Lines 0 to 9 are wired, in this order, to the parallel port, floppy, sound, video, network, SCSI, keyboard, mouse, serial 0 and serial 1. Lines 10 to 15 are spare.

Top module: `vic_top`

## Requirements
- R1: After reset is released and before any write, the mask is 0x0000, `irq_o` is 0 and `rdata_o` is 0x0000.
- R2: On every clock, each source bit takes the level of its line. A line that drops clears its bit on the next clock, with no acknowledge needed.
- R3: `irq_o` is high exactly when the AND of the source bits and the mask is nonzero. It follows a change on a line or in the mask one clock later.
- R4: A read at offset 0 returns ((n + 1) << 2), where n is the lowest-numbered bit that is both active and enabled. The lowest index has the highest priority.
- R5: A read at offset 0 returns 0x0000 when no source is both active and enabled, even if masked lines are high.
- R6: A write at offset 2 with both byte enables set loads the mask. A read at offset 2 returns the mask.
- R7: A write at offset 2 with `be_i` = 01 updates only mask bits 7:0, and with `be_i` = 10 updates only bits 15:8. The other byte keeps its value.
- R8: Offset 0 is read-only. A write there changes neither the mask nor `irq_o`.
- R9: Reads from any offset other than 0 and 2 return 0x0000, and writes to them are ignored. Address bit 0 is not decoded.
- R10: Read data appears on `rdata_o` one clock after the read request. It holds that value until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 16 | Level-sensitive interrupt lines, bit 0 has the highest priority |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the access |
| be_i | input | 2 | Byte enables for writes: bit 0 selects bits 7:0, bit 1 selects bits 15:8 |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The vector read is driven with several patterns. A single active line at each end of the range checks the code arithmetic. Several simultaneous lines show that the lowest enabled index wins over higher ones. All lines high under an empty mask, and under a mask that admits only one high bit, show that the mask filters before the priority choice rather than after it. Byte-lane writes, writes to the read-only and unmapped offsets, and a line that drops between two reads separate the merge, decode and level-tracking behaviour from one another. The combined output is sampled in the cycle before and the cycle after a change to pin its one-clock latency.

// File: rtl/vic_pkg.sv
package vic_pkg;
  parameter int unsigned NUM_SRC   = 16;
  parameter int unsigned DATA_W    = 16;
  parameter int unsigned ADDR_W    = 12;
  parameter int unsigned VEC_SHIFT = 2;

  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  // halfword index of each register (byte offset >> 1)
  localparam logic [ADDR_W-2:0] VEC_HW  = '0;
  localparam logic [ADDR_W-2:0] MASK_HW = (ADDR_W-1)'(1);

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/vic_src_reg.sv
module vic_src_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] src_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_o[g] <= 1'b0;
      else         src_o[g] <= lines_i[g];
    end
  end
endmodule

// File: rtl/vic_mask_reg.sv
module vic_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [W/8-1:0] be_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   mask_d_o,
  output logic [W-1:0]   mask_q_o
);
  localparam int unsigned NL = W / 8;

  // per-lane merge: unselected lanes keep the held byte
  for (genvar l = 0; l < NL; l++) begin : g_lane
    always_comb begin
      if (wr_i && be_i[l]) mask_d_o[l*8 +: 8] = wdata_i[l*8 +: 8];
      else                 mask_d_o[l*8 +: 8] = mask_q_o[l*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q_o <= '0;
    else         mask_q_o <= mask_d_o;
  end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned N     = 16,
  parameter int unsigned W     = 16,
  parameter int unsigned SHIFT = 2
) (
  input  logic [N-1:0] pend_i,
  output logic [W-1:0] vec_o
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] code;

  // scan from the top so the lowest set index is kept last
  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) code = CW'(i + 1);
    end
  end

  assign vec_o = W'(code) << SHIFT;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] irq_lines_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] src_q;
  logic [DATA_W-1:0]  mask_q;
  logic [DATA_W-1:0]  mask_d;
  logic [DATA_W-1:0]  vec;
  logic [NUM_SRC-1:0] pend;
  reg_sel_e           sel;
  logic               mask_wr;
  logic [DATA_W-1:0]  rd_mux;

  always_comb begin
    unique case (addr_i[ADDR_W-1:1])
      VEC_HW:  sel = SEL_VEC;
      MASK_HW: sel = SEL_MASK;
      default: sel = SEL_NONE;
    endcase
  end

  assign mask_wr = req_i && we_i && (sel == SEL_MASK);

  vic_src_reg #(.N(NUM_SRC)) u_src (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (irq_lines_i),
    .src_o   (src_q)
  );

  vic_mask_reg #(.W(DATA_W)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mask_wr),
    .be_i     (be_i),
    .wdata_i  (wdata_i),
    .mask_d_o (mask_d),
    .mask_q_o (mask_q)
  );

  assign pend = src_q & mask_q[NUM_SRC-1:0];

  vic_prio_enc #(.N(NUM_SRC), .W(DATA_W), .SHIFT(VEC_SHIFT)) u_enc (
    .pend_i (pend),
    .vec_o  (vec)
  );

  // next-state form keeps irq_o aligned with src_q/mask_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(irq_lines_i & mask_d[NUM_SRC-1:0]);
  end

  always_comb begin
    unique case (sel)
      SEL_VEC:  rd_mux = vec;
      SEL_MASK: rd_mux = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk
  import vic_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_lines_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [LANES-1:0]   be_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] src_q,
  input logic [DATA_W-1:0]  mask_q
);
  logic rd_req, wr_vec, wr_none, wr_mask_full;
  assign rd_req       = req_i && !we_i;
  assign wr_vec       = req_i && we_i && (addr_i[ADDR_W-1:1] == VEC_HW);
  assign wr_none      = req_i && we_i && (addr_i[ADDR_W-1:1] != VEC_HW)
                        && (addr_i[ADDR_W-1:1] != MASK_HW);
  assign wr_mask_full = req_i && we_i && (addr_i[ADDR_W-1:1] == MASK_HW) && (&be_i);

  a_r2_src_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (src_q == $past(irq_lines_i)));

  a_r3_irq_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(src_q & mask_q[NUM_SRC-1:0])));

  a_r6_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_full |=> (mask_q == $past(wdata_i)));

  a_r8_vec_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vec |=> $stable(mask_q));

  a_r9_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_none |=> $stable(mask_q));

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_o));
endmodule

bind vic_top vic_top_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_lines_i (irq_lines_i),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .be_i        (be_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .src_q       (src_q),
  .mask_q      (mask_q)
);

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_lines_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [1:0]  be_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vic_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_lines_i(irq_lines_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  localparam int NV = 8;
  localparam logic [15:0] T_LINES [NV] = '{16'h0001, 16'h8000, 16'h0006, 16'hFFFF,
                                           16'h00F0, 16'h0000, 16'hFFFF, 16'h0201};
  localparam logic [15:0] T_MASK  [NV] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000,
                                           16'h00C0, 16'hFFFF, 16'h8000, 16'h0200};
  localparam logic [15:0] T_VEC   [NV] = '{16'd4, 16'd64, 16'd8, 16'd0,
                                           16'd28, 16'd0, 16'd64, 16'd40};
  localparam logic        T_IRQ   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0,
                                           1'b1, 1'b0, 1'b1, 1'b1};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [1:0] b, logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; be_i = b; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 irq", {15'd0, irq_o}, 16'd0);
    check("R1 rdata", rdata_o, 16'd0);
    rd(12'h002, d); check("R1 mask", d, 16'h0000);
    irq_lines_i = 16'hFFFF;
    @(negedge clk_i);
    rd(12'h000, d); check("R5 masked lines", d, 16'h0000);
    check("R5 irq", {15'd0, irq_o}, 16'd0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      irq_lines_i = T_LINES[i];
      wr(12'h002, 2'b11, T_MASK[i]);
      check("R3 irq table", {15'd0, irq_o}, {15'd0, T_IRQ[i]});
      rd(12'h000, d); check("R4 vector table", d, T_VEC[i]);
      rd(12'h002, d); check("R6 mask readback", d, T_MASK[i]);
    end

    // R3 latency on line change
    wr(12'h002, 2'b11, 16'h0010);
    @(negedge clk_i);
    irq_lines_i = 16'h0000;
    @(negedge clk_i);
    check("R3 irq low", {15'd0, irq_o}, 16'd0);
    irq_lines_i = 16'h0010;
    #1 check("R3 irq not yet", {15'd0, irq_o}, 16'd0);
    @(negedge clk_i);
    check("R3 irq one clock", {15'd0, irq_o}, 16'd1);

    // R2 drop clears with no acknowledge
    rd(12'h000, d); check("R2 active", d, 16'd20);
    irq_lines_i = 16'h0000;
    @(negedge clk_i);
    rd(12'h000, d); check("R2 dropped", d, 16'd0);

    // R7 byte merges
    wr(12'h002, 2'b11, 16'hFFFF);
    wr(12'h002, 2'b01, 16'h1234);
    rd(12'h002, d); check("R7 low byte", d, 16'hFF34);
    wr(12'h003, 2'b10, 16'hAB00);
    rd(12'h002, d); check("R7 high byte", d, 16'hAB34);

    // R8 read-only vector register
    irq_lines_i = 16'h0004;
    wr(12'h000, 2'b11, 16'h0000);
    rd(12'h002, d); check("R8 mask kept", d, 16'hAB34);
    check("R8 irq kept", {15'd0, irq_o}, 16'd1);
    rd(12'h000, d); check("R8 vector", d, 16'd12);

    // R9 unmapped
    wr(12'h004, 2'b11, 16'h0000);
    wr(12'hFFE, 2'b11, 16'h0000);
    rd(12'h002, d); check("R9 mask kept", d, 16'hAB34);
    rd(12'h004, d); check("R9 read 4", d, 16'h0000);
    rd(12'h006, d); check("R9 read 6", d, 16'h0000);

    // R10 latency and hold
    rd(12'h002, d);
    irq_lines_i = 16'h0000;
    repeat (3) @(negedge clk_i);
    check("R10 hold", rdata_o, 16'hAB34);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 12'h000;
    #1 check("R10 not yet", rdata_o, 16'hAB34);
    @(negedge clk_i);
    req_i = 1'b0;
    check("R10 one clock", rdata_o, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule